// File: doc/BRIEF.md
# Ternary-Coefficient Radix-4 Butterfly

This block combines four complex samples into four complex results. It is the single butterfly stage of a 16-point Walsh-Hadamard-Fourier style transform. Each of the sixteen coefficient products is one of {-1, 0, +1}, so the block needs no hardware multiplier. Each coefficient arrives as a 2-bit code. A code selects the operand, its negation or zero, and four such terms are summed for each output part. Real and imaginary words share one stream at the input and at the output.

A group is eight consecutive input words. A pulse on `inValid` marks the first word and captures the coefficient matrix in the same cycle. Once the eighth word is in, the sums are registered and played out as eight consecutive words. A pulse on `outValid` marks the first of those words. The latency is fixed. A new group may begin right after the last word of the previous one, so the block sustains one group every eight cycles.

Top module: `tern_bfly4`

## Requirements
- R1: While `rstN` is low and after its release, `outValid` is 0 and `dataOut` is 0 until a group has been processed.
- R2: A cycle with `inValid` high while no group is being collected starts a group. That word and the next seven cycles' words are taken as re0, im0, re1, im1, re2, im2, re3, im3.
- R3: Coefficient codes: 2'b01 selects +x, 2'b11 selects -x, and 2'b00 and 2'b10 select zero. The code for output k and input n sits at `coefIn[(4*k+n)*2 +: 2]`.
- R4: Output k is the sum over n of code(k,n) applied to input n. The same code applies to the real and the imaginary parts. Results are signed two's complement of W+2 bits and never overflow.
- R5: Negating the most negative W-bit input, -2^(W-1), yields 2^(W-1)-1.
- R6: Results leave as eight consecutive words in the order re0, im0, re1, im1, re2, im2, re3, im3. `outValid` is high only on the re0 word. `dataOut` is 0 outside an output group.
- R7: The re0 result appears exactly 9 cycles after the cycle that started the group, for any data or coefficients. `outValid` is low in the cycle before it.
- R8: `inValid` pulses during the seven words that follow the start of a group are ignored.
- R9: A new group may start in the cycle right after the last word of the previous group. Both groups then produce correct, contiguous results.
- R10: The coefficients are taken only in the cycle that starts a group. Changes on `coefIn` later in the group have no effect on its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Marks the first (re0) word of an input group |
| dataIn | input | W | Interleaved signed input word |
| coefIn | input | 32 | Sixteen 2-bit coefficient codes |
| outValid | output | 1 | Marks the first (re0) word of an output group |
| dataOut | output | W+2 | Interleaved signed result word |

## Verification
On every cycle, the assertions check the output framing: `outValid` lasts exactly one cycle, and it follows the load strobe and the group start by exactly the fixed delay. They also check that a coefficient row made only of zero codes leaves its result words at zero. The arithmetic itself can only be shown by the bench's scenarios. Those scenarios cover the sums under identity, Hadamard, all-zero and mixed coefficient sets, word growth at full scale, saturation of negated minimum values, ignored mid-group pulses and coefficient changes, and back-to-back groups.

// File: rtl/tern_bfly4_pkg.sv
package tern_bfly4_pkg;
  // radix-4: four complex points, two words per point
  localparam int BF_PTS   = 4;
  localparam int BF_WORDS = 2 * BF_PTS;
  localparam int BF_IDXW  = $clog2(BF_WORDS);
  localparam int BF_CODEW = 2;
  localparam int BF_COEFW = BF_PTS * BF_PTS * BF_CODEW;
  localparam logic [BF_IDXW-1:0] BF_LAST = BF_IDXW'(BF_WORDS - 1);

  // strobes from control to datapath
  typedef struct packed {
    logic               capFirst;
    logic               capNext;
    logic [BF_IDXW-1:0] wrIdx;
    logic               loadOut;
    logic               outActive;
    logic [BF_IDXW-1:0] rdIdx;
  } bfly_ctl_t;
endpackage

// File: rtl/tern_bfly4_ctl.sv
module tern_bfly4_ctl
  import tern_bfly4_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      inValid,
  output bfly_ctl_t ctl,
  output logic      outValid
);
  logic               collecting;
  logic [BF_IDXW-1:0] inCnt;
  logic               loadPend;
  logic               outActive;
  logic [BF_IDXW-1:0] outCnt;
  logic               accept;

  assign accept = inValid && !collecting;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      collecting <= 1'b0;
      inCnt      <= '0;
      loadPend   <= 1'b0;
      outActive  <= 1'b0;
      outCnt     <= '0;
    end else begin
      if (accept) begin
        collecting <= 1'b1;
        inCnt      <= BF_IDXW'(1);
      end else if (collecting) begin
        inCnt <= inCnt + 1'b1;
        if (inCnt == BF_LAST) collecting <= 1'b0;
      end
      loadPend <= collecting && (inCnt == BF_LAST);
      if (loadPend) begin
        outActive <= 1'b1;
        outCnt    <= '0;
      end else if (outActive) begin
        outCnt <= outCnt + 1'b1;
        if (outCnt == BF_LAST) outActive <= 1'b0;
      end
    end
  end

  always_comb begin
    ctl.capFirst  = accept;
    ctl.capNext   = collecting;
    ctl.wrIdx     = accept ? '0 : inCnt;
    ctl.loadOut   = loadPend;
    ctl.outActive = outActive;
    ctl.rdIdx     = outCnt;
  end

  assign outValid = outActive && (outCnt == '0);

  // cycles since reset, saturating, so the latency check never looks before reset
  logic [3:0] upCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) upCnt <= '0;
    else if (upCnt != 4'hF) upCnt <= upCnt + 1'b1;
  end

  // R6
  out_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R7
  load_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    loadPend |=> outValid);

  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> $past(loadPend));

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (upCnt >= 4'd10) && $past(accept, 9) |-> outValid);
endmodule

// File: rtl/tern_bfly4_dp.sv
module tern_bfly4_dp
  import tern_bfly4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  bfly_ctl_t           ctl,
  input  logic [W-1:0]        dataIn,
  input  logic [BF_COEFW-1:0] coefIn,
  output logic [W+1:0]        dataOut
);
  localparam int OW = W + 2;
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAX_V = ~MIN_V;

  logic [W-1:0]        sampBuf [BF_WORDS];
  logic [BF_COEFW-1:0] coefReg;
  logic [OW-1:0]       sumW    [BF_WORDS];
  logic [OW-1:0]       outReg  [BF_WORDS];

  // ternary selection with saturating negation, sign-extended to result width
  function automatic logic [OW-1:0] ternSel(input logic [1:0] code, input logic [W-1:0] x);
    logic [W-1:0] v;
    case (code)
      2'b01:   v = x;
      2'b11:   v = (x == MIN_V) ? MAX_V : (~x + 1'b1);
      default: v = '0;
    endcase
    return {{(OW-W){v[W-1]}}, v};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BF_WORDS; i++) sampBuf[i] <= '0;
      coefReg <= '0;
    end else if (ctl.capFirst) begin
      sampBuf[0] <= dataIn;
      coefReg    <= coefIn;
    end else if (ctl.capNext) begin
      sampBuf[ctl.wrIdx] <= dataIn;
    end
  end

  // one four-term adder tree per output word
  for (genvar j = 0; j < BF_WORDS; j++) begin : g_word
    localparam int K = j / 2;
    localparam int P = j % 2;
    logic [OW-1:0] acc;
    always_comb begin
      acc = '0;
      for (int n = 0; n < BF_PTS; n++)
        acc = acc + ternSel(coefReg[(K*BF_PTS+n)*BF_CODEW +: BF_CODEW], sampBuf[2*n+P]);
    end
    assign sumW[j] = acc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < BF_WORDS; i++) outReg[i] <= '0;
    end else if (ctl.loadOut) begin
      for (int i = 0; i < BF_WORDS; i++) outReg[i] <= sumW[i];
    end
  end

  assign dataOut = ctl.outActive ? outReg[ctl.rdIdx] : '0;

  // row 0 holds only zero codes when the low bit of every code is clear
  logic rowZero0;
  always_comb begin
    rowZero0 = 1'b1;
    for (int n = 0; n < BF_PTS; n++)
      if (coefReg[n*BF_CODEW]) rowZero0 = 1'b0;
  end

  // R3
  zero_row_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.loadOut && rowZero0 |=> (outReg[0] == '0) && (outReg[1] == '0));
endmodule

// File: rtl/tern_bfly4.sv
module tern_bfly4
  import tern_bfly4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic [W-1:0]  dataIn,
  input  logic [31:0]   coefIn,
  output logic          outValid,
  output logic [W+1:0]  dataOut
);
  bfly_ctl_t ctl;

  tern_bfly4_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctl      (ctl),
    .outValid (outValid)
  );

  tern_bfly4_dp #(.W(W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .dataIn  (dataIn),
    .coefIn  (coefIn),
    .dataOut (dataOut)
  );
endmodule

// File: tb/tern_bfly4_tb.sv
module tern_bfly4_tb;
  localparam int W  = 16;
  localparam int OW = W + 2;
  localparam int NV = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          inValid = 1'b0;
  logic [W-1:0]  dataIn = '0;
  logic [31:0]   coefIn = '0;
  logic          outValid;
  logic [OW-1:0] dataOut;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  tern_bfly4 #(.W(W)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .dataIn(dataIn),
    .coefIn(coefIn), .outValid(outValid), .dataOut(dataOut)
  );

  // words packed {im3,re3,im2,re2,im1,re1,im0,re0}
  localparam logic [8*W-1:0] VW [NV] = '{
    {16'h8000, 16'h7FFF, 16'h002A, 16'hFB2E, 16'h012C, 16'h0007, 16'hFFFB, 16'h0064},
    {16'h8000, 16'h7FFF, 16'h002A, 16'hFB2E, 16'h012C, 16'h0007, 16'hFFFB, 16'h0064},
    {16'h8000, 16'h7FFF, 16'h002A, 16'hFB2E, 16'h012C, 16'h0007, 16'hFFFB, 16'h0064},
    {8{16'h7FFF}},
    {8{16'h8000}},
    {16'hF0F0, 16'h0F0F, 16'hC000, 16'h4000, 16'hFFFF, 16'h0001, 16'hEDCB, 16'h1234}
  };
  // identity, Hadamard, all code 10, all +1, all -1, mixed
  localparam logic [31:0] VC [NV] = '{
    32'h40100401, 32'h7DF5DD55, 32'hAAAAAAAA, 32'h55555555, 32'hFFFFFFFF, 32'h9C3BE146
  };

  function automatic logic [OW-1:0] refTerm(input logic [1:0] c, input logic [W-1:0] x);
    logic signed [OW-1:0] sx;
    sx = OW'($signed(x));
    if (c == 2'b01) return sx;
    if (c == 2'b11) return (x == 16'h8000) ? OW'(32767) : -sx;
    return '0;
  endfunction

  function automatic logic [OW-1:0] refOut(input logic [8*W-1:0] w, input logic [31:0] c, input int j);
    logic [OW-1:0] s;
    int k, p;
    k = j / 2;
    p = j % 2;
    s = '0;
    for (int n = 0; n < 4; n++)
      s = s + refTerm(c[(4*k+n)*2 +: 2], w[(2*n+p)*W +: W]);
    return s;
  endfunction

  task automatic chk(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // called just after a falling edge; leaves after the group's eighth word
  task automatic sendGroup(input logic [8*W-1:0] w, input logic [31:0] c,
                           input bit junk, input bit coefFlip);
    for (int j = 0; j < 8; j++) begin
      inValid = (j == 0) || (junk && (j % 2 == 1));
      dataIn  = w[j*W +: W];
      coefIn  = (coefFlip && j > 0) ? ~c : c;
      @(negedge clk);
    end
    inValid = 1'b0;
  endtask

  task automatic expectGroup(input logic [8*W-1:0] w, input logic [31:0] c, input string tag);
    repeat (8) @(negedge clk);
    chk({tag, " R7 outValid before first word"}, OW'(outValid), OW'(0));
    @(negedge clk);
    chk({tag, " R7 outValid on first word"}, OW'(outValid), OW'(1));
    for (int j = 0; j < 8; j++) begin
      if (j > 0) begin
        @(negedge clk);
        chk({tag, " R6 outValid inside group"}, OW'(outValid), OW'(0));
      end
      chk({tag, " R4 word"}, dataOut, refOut(w, c, j));
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outValid in reset", OW'(outValid), OW'(0));
    chk("R1 dataOut in reset", dataOut, OW'(0));
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 outValid after reset", OW'(outValid), OW'(0));
    chk("R1 dataOut after reset", dataOut, OW'(0));

    // table: R2, R3 (identity, Hadamard, code 10), R4 growth, R5 saturation
    for (int v = 0; v < NV; v++) begin
      fork
        sendGroup(VW[v], VC[v], 1'b0, 1'b0);
        expectGroup(VW[v], VC[v], $sformatf("R2 R3 R5 vec%0d", v));
      join
    end

    // R8: stray inValid pulses on the odd words of a group
    fork
      sendGroup(VW[1], VC[1], 1'b1, 1'b0);
      expectGroup(VW[1], VC[1], "R8");
    join

    // R10: coefficients inverted after the first word
    fork
      sendGroup(VW[5], VC[5], 1'b0, 1'b1);
      expectGroup(VW[5], VC[5], "R10");
    join

    // R9: two groups with no gap
    fork
      begin
        sendGroup(VW[5], VC[1], 1'b0, 1'b0);
        sendGroup(VW[0], VC[5], 1'b0, 1'b0);
      end
      expectGroup(VW[5], VC[1], "R9 first");
      begin
        repeat (8) @(negedge clk);
        expectGroup(VW[0], VC[5], "R9 second");
      end
    join

    repeat (3) @(negedge clk);
    chk("R6 dataOut idle after groups", dataOut, OW'(0));
    chk("R6 outValid idle after groups", OW'(outValid), OW'(0));

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule